// File: doc/BRIEF.md
# Single-Bus Multicycle Datapath with Fetch and NOT Execution

This block is a 16-bit processor datapath in which every register-to-register transfer travels over one common bus. Four sources can be gated onto that bus: the program counter, the memory data register, the ALU result and the address-select mux. Any number of registers can capture the bus in the same clock, but each one loads only when its own load enable is high. A four-phase sequencer produces the gate and load enables. The first three phases fetch an instruction, and the fourth executes it.

The only instruction that is executed is the bitwise inverse of one register into another. Any other opcode is decoded and then retired with no effect. The memory is an internal word array that answers in one cycle. It holds a program that is computed from the address, and the register file resets to computed seed values. This lets the whole machine run from reset with no external stimulus. The bus, its owner, the register write strobe and the architectural registers are brought out so that a bench can observe every transfer.

Top module: `nbus_core`

## Requirements
- R1: After a synchronous active-low reset, the block is in the following state. The PC is 0. The phase is FETCH_A, encoded 0. The flags are Z only, so `nzp_q` = 3'b010 with bit 2 = N, bit 1 = Z and bit 0 = P. Register k holds (k × 16'h2493) mod 2^16.
- R2: `bus_owner` has at most one bit set. Bit 0 is the PC, bit 1 is MDR, bit 2 is the ALU and bit 3 is the address mux. When no bit is set, `bus_val` is 0.
- R3: In phase FETCH_A, the PC is on the bus and MAR captures it. At the same clock edge the PC becomes PC+1. The PC does not change in any other phase.
- R4: In phase FETCH_B (encoded 1), no source drives the bus, and MDR loads the memory word at address MAR mod 64.
- R5: In phase FETCH_C (encoded 2), MDR is on the bus and IR captures it. IR does not change in any other phase.
- R6: The memory word at address a is built as follows. When a mod 4 = 3 it is {4'b0000, a[2:0], a[5:3], 6'b000000}. Otherwise it is {4'b1001, a[2:0], a[5:3], 6'b111111}. In the instruction, IR[15:12] is the opcode, IR[11:9] is the destination and IR[8:6] is the source.
- R7: In phase EXECUTE (encoded 3) with opcode 4'b1001, the ALU drives the bitwise inverse of the source register onto the bus. The destination register is written with that value.
- R8: On that NOT execute, the flags are loaded from the bus value. N is set for a negative two's-complement value, Z for zero and P for a positive value, and exactly one flag is set at all times.
- R9: In EXECUTE with any other opcode, no source drives the bus, no register is written and the flags keep their value. The flags never change outside EXECUTE.
- R10: The phases step FETCH_A, FETCH_B, FETCH_C, EXECUTE and then return to FETCH_A, so each instruction takes four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_q | output | 16 | Program counter |
| ir_q | output | 16 | Instruction register |
| nzp_q | output | 3 | Condition flags {N,Z,P} |
| phase_q | output | 2 | Sequencer phase |
| bus_val | output | 16 | Value on the shared bus |
| bus_owner | output | 4 | Gate enables {addr mux, ALU, MDR, PC} |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 3 | Register file write address |

## Verification
The bench runs the program through two full passes of the 64-word memory, so the PC wraps past the array size. A design that indexed memory with the wrong address bits would then fetch the wrong word. The program chains inversions so that the flags take on N, Z and P. A design that tested the sign incorrectly, or that loaded the flags on the skipped opcodes, would show different flags. Every fourth word is a non-NOT opcode. A design that wrote the register file on those words would corrupt the register values that later inversions read. On each cycle the bench checks the bus owner, so a gate enable left on for an extra phase is reported as two drivers or as a wrong bus value.

// File: rtl/nbus_pkg.sv
// Package: types, encodings and computed contents shared by the datapath.
// Assumes a 16-bit word and the fixed instruction field layout below.
package nbus_pkg;

    localparam int WORD_W = 16;

    localparam logic [3:0] OP_BR  = 4'b0000;
    localparam logic [3:0] OP_ADD = 4'b0001;
    localparam logic [3:0] OP_AND = 4'b0101;
    localparam logic [3:0] OP_LDR = 4'b0110;
    localparam logic [3:0] OP_NOT = 4'b1001;
    localparam logic [3:0] OP_LDI = 4'b1010;
    localparam logic [3:0] OP_LEA = 4'b1110;

    typedef enum logic [1:0] {
        PH_FETCH_A = 2'd0,
        PH_FETCH_B = 2'd1,
        PH_FETCH_C = 2'd2,
        PH_EXECUTE = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        PCSRC_INC   = 2'd0,
        PCSRC_ADDER = 2'd1,
        PCSRC_BUS   = 2'd2
    } pc_src_t;

    typedef enum logic {
        MARSRC_ADDER = 1'b0,
        MARSRC_ZEXT  = 1'b1
    } mar_src_t;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_AND  = 2'd1,
        ALU_INV  = 2'd2,
        ALU_PASS = 2'd3
    } alu_op_t;

    typedef struct packed {
        logic     gate_pc;
        logic     gate_mdr;
        logic     gate_alu;
        logic     gate_amux;
        logic     ld_mar;
        logic     ld_pc;
        logic     ld_mdr;
        logic     mem_en;
        logic     ld_ir;
        logic     ld_reg;
        logic     ld_cc;
        logic     sr2_imm;
        pc_src_t  pc_src;
        mar_src_t mar_src;
        alu_op_t  alu_op;
    } ctrl_t;

    // Opcodes that are allowed to update the condition flags.
    function automatic logic op_sets_flags(input logic [3:0] op);
        return (op == OP_ADD) || (op == OP_AND) || (op == OP_NOT) ||
               (op == OP_LDI) || (op == OP_LDR) || (op == OP_LEA);
    endfunction

    // Computed program image: NOT words, with every fourth word a non-NOT opcode.
    function automatic logic [WORD_W-1:0] image_word(input int unsigned idx);
        logic [2:0] lo;
        logic [2:0] hi;
        lo = 3'(idx % 8);
        hi = 3'((idx / 8) % 8);
        if ((idx % 4) == 3)
            return {OP_BR, lo, hi, 6'b000000};
        else
            return {OP_NOT, lo, hi, 6'b111111};
    endfunction

endpackage

// File: rtl/nbus_seq.sv
// Sequencer: walks fetch A/B/C then execute, and emits the gate and load
// enables for each phase. Assumes IR is stable during EXECUTE.
module nbus_seq
    import nbus_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   opcode,
    output phase_t       phase,
    output ctrl_t        ctrl
);

    // Phase register: advance one step per clock and wrap to FETCH_A.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_FETCH_A;
        else begin
            unique case (phase)
                PH_FETCH_A: phase <= PH_FETCH_B;
                PH_FETCH_B: phase <= PH_FETCH_C;
                PH_FETCH_C: phase <= PH_EXECUTE;
                default:    phase <= PH_FETCH_A;
            endcase
        end
    end

    // Control decode: one gate enable at most, plus the loads of this phase.
    always_comb begin
        ctrl         = '0;
        ctrl.pc_src  = PCSRC_INC;
        ctrl.mar_src = MARSRC_ADDER;
        ctrl.alu_op  = ALU_PASS;
        unique case (phase)
            PH_FETCH_A: begin
                ctrl.gate_pc = 1'b1;
                ctrl.ld_mar  = 1'b1;
                ctrl.ld_pc   = 1'b1;
                ctrl.pc_src  = PCSRC_INC;
            end
            PH_FETCH_B: begin
                ctrl.mem_en = 1'b1;
                ctrl.ld_mdr = 1'b1;
            end
            PH_FETCH_C: begin
                ctrl.gate_mdr = 1'b1;
                ctrl.ld_ir    = 1'b1;
            end
            default: begin
                if (opcode == OP_NOT) begin
                    ctrl.alu_op   = ALU_INV;
                    ctrl.gate_alu = 1'b1;
                    ctrl.ld_reg   = 1'b1;
                    ctrl.ld_cc    = op_sets_flags(opcode);
                end
            end
        endcase
    end

endmodule

// File: rtl/nbus_regfile.sv
// Register file: N entries, two combinational read ports and one write port.
// Assumes writes are single-port; entry k resets to k*SEED.
module nbus_regfile #(
    parameter int W    = 16,
    parameter int N    = 8,
    parameter int SEED = 16'h2493,
    localparam int AW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr1,
    input  logic [AW-1:0] raddr2,
    output logic [W-1:0]  rdata1,
    output logic [W-1:0]  rdata2
);

    logic [W-1:0] cells [N];

    for (genvar k = 0; k < N; k++) begin : g_entry
        // Entry k: seed on reset, otherwise take write data when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[k] <= W'(k * SEED);
            else if (we && (waddr == AW'(k)))
                cells[k] <= wdata;
        end
    end

    // Read ports: combinational.
    always_comb begin
        rdata1 = cells[raddr1];
        rdata2 = cells[raddr2];
    end

endmodule

// File: rtl/nbus_mem.sv
// Word memory with single-cycle read. Contents are loaded from the computed
// image during reset. Assumes the caller registers the read data (MDR).
module nbus_mem
    import nbus_pkg::*;
#(
    parameter int AW     = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [AW-1:0]     addr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] cells [DEPTH];

    // Array contents: written from the image while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= image_word(i);
        end
    end

    // Read path: the word at addr when enabled, otherwise zero.
    always_comb begin
        rdata = en ? cells[addr] : '0;
    end

endmodule

// File: rtl/nbus_alu.sv
// ALU: add, and, bitwise inverse or pass of operand A. Purely combinational.
module nbus_alu
    import nbus_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_t       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y
);

    // Operation select.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_AND: y = a & b;
            ALU_INV: y = ~a;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/nbus_core.sv
// Top: single-bus datapath. Holds PC, MAR, MDR, IR and the N/Z/P flags, and
// connects the sequencer, register file, memory and ALU. Assumes the sequencer
// never enables two gates at once; the bus mux takes the first enabled one.
module nbus_core
    import nbus_pkg::*;
#(
    parameter int MEM_AW  = 6,
    parameter int REG_N   = 8,
    parameter int RF_SEED = 16'h2493,
    localparam int RAW    = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] pc_q,
    output logic [WORD_W-1:0] ir_q,
    output logic [2:0]        nzp_q,
    output logic [1:0]        phase_q,
    output logic [WORD_W-1:0] bus_val,
    output logic [3:0]        bus_owner,
    output logic              rf_we,
    output logic [RAW-1:0]    rf_waddr
);

    phase_t            phase;
    ctrl_t             ctrl;
    logic [WORD_W-1:0] pc, mar, mdr, ir;
    logic [2:0]        nzp;
    logic [WORD_W-1:0] bus;
    logic [WORD_W-1:0] pc_next, adder_out, amux_out;
    logic [WORD_W-1:0] sr1_val, sr2_val, alu_b, alu_out, mem_rdata;

    nbus_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (ir[15:12]),
        .phase  (phase),
        .ctrl   (ctrl)
    );

    nbus_regfile #(.W(WORD_W), .N(REG_N), .SEED(RF_SEED)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctrl.ld_reg),
        .waddr  (ir[9 +: RAW]),
        .wdata  (bus),
        .raddr1 (ir[6 +: RAW]),
        .raddr2 (ir[0 +: RAW]),
        .rdata1 (sr1_val),
        .rdata2 (sr2_val)
    );

    nbus_mem #(.AW(MEM_AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl.mem_en),
        .addr  (mar[MEM_AW-1:0]),
        .rdata (mem_rdata)
    );

    nbus_alu #(.W(WORD_W)) u_alu (
        .op (ctrl.alu_op),
        .a  (sr1_val),
        .b  (alu_b),
        .y  (alu_out)
    );

    // Second ALU operand: register or sign-extended 5-bit immediate.
    always_comb begin
        alu_b = ctrl.sr2_imm ? {{(WORD_W-5){ir[4]}}, ir[4:0]} : sr2_val;
    end

    // Address adder: PC plus sign-extended 9-bit offset.
    always_comb begin
        adder_out = pc + {{(WORD_W-9){ir[8]}}, ir[8:0]};
    end

    // Address-select mux: adder result or zero-extended low byte of IR.
    always_comb begin
        amux_out = (ctrl.mar_src == MARSRC_ZEXT) ? {{(WORD_W-8){1'b0}}, ir[7:0]}
                                                 : adder_out;
    end

    // PC source mux: increment, adder or bus.
    always_comb begin
        unique case (ctrl.pc_src)
            PCSRC_ADDER: pc_next = adder_out;
            PCSRC_BUS:   pc_next = bus;
            default:     pc_next = pc + 1'b1;
        endcase
    end

    // Shared bus: value of the enabled source, zero when none is enabled.
    always_comb begin
        if (ctrl.gate_pc)        bus = pc;
        else if (ctrl.gate_mdr)  bus = mdr;
        else if (ctrl.gate_alu)  bus = alu_out;
        else if (ctrl.gate_amux) bus = amux_out;
        else                     bus = '0;
    end

    // Program counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc <= '0;
        else if (ctrl.ld_pc) pc <= pc_next;
    end

    // Memory address register, loaded from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)           mar <= '0;
        else if (ctrl.ld_mar) mar <= bus;
    end

    // Memory data register, loaded from the memory read port.
    always_ff @(posedge clk) begin
        if (!rst_n)           mdr <= '0;
        else if (ctrl.ld_mdr) mdr <= mem_rdata;
    end

    // Instruction register, loaded from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)          ir <= '0;
        else if (ctrl.ld_ir) ir <= bus;
    end

    // Condition flags: sign and zero test of the bus value when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nzp <= 3'b010;
        else if (ctrl.ld_cc) begin
            if (bus[WORD_W-1])  nzp <= 3'b100;
            else if (bus == '0) nzp <= 3'b010;
            else                nzp <= 3'b001;
        end
    end

    // Observation outputs.
    always_comb begin
        pc_q      = pc;
        ir_q      = ir;
        nzp_q     = nzp;
        phase_q   = phase;
        bus_val   = bus;
        bus_owner = {ctrl.gate_amux, ctrl.gate_alu, ctrl.gate_mdr, ctrl.gate_pc};
        rf_we     = ctrl.ld_reg;
        rf_waddr  = ir[9 +: RAW];
    end

endmodule

// File: rtl/nbus_core_chk.sv
// Checker: temporal properties of the datapath ports, bound to nbus_core.
module nbus_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] pc_q,
    input logic [15:0] ir_q,
    input logic [2:0]  nzp_q,
    input logic [1:0]  phase_q,
    input logic [15:0] bus_val,
    input logic [3:0]  bus_owner,
    input logic        rf_we,
    input logic [2:0]  rf_waddr
);

    a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_owner));

    a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_owner == 4'b0000) |-> (bus_val == 16'h0000));

    a_r3_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == 2'd0) |=> (pc_q == $past(pc_q) + 16'd1));

    a_r3_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != 2'd0) |=> $stable(pc_q));

    a_r5_ir_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != 2'd2) |=> $stable(ir_q));

    a_r7_write_only_not: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (phase_q == 2'd3 && ir_q[15:12] == 4'b1001 && bus_owner == 4'b0100));

    a_r8_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(nzp_q) == 1);

    a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != 2'd3 || ir_q[15:12] != 4'b1001) |=> $stable(nzp_q));

    a_r10_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_q == $past(phase_q) + 2'd1));

endmodule

bind nbus_core nbus_core_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_q      (pc_q),
    .ir_q      (ir_q),
    .nzp_q     (nzp_q),
    .phase_q   (phase_q),
    .bus_val   (bus_val),
    .bus_owner (bus_owner),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr)
);

// File: tb/nbus_core_tb_top.sv
// Bench: runs the computed program twice through memory and compares each
// cycle's bus, owner, write strobe, PC, IR and flags with a model built from
// the requirements.
module nbus_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_INSTR    = 140;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_q, ir_q, bus_val;
    logic [2:0]  nzp_q, rf_waddr;
    logic [1:0]  phase_q;
    logic [3:0]  bus_owner;
    logic        rf_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nbus_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_q      (pc_q),
        .ir_q      (ir_q),
        .nzp_q     (nzp_q),
        .phase_q   (phase_q),
        .bus_val   (bus_val),
        .bus_owner (bus_owner),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Program word at address a, per R6.
    function automatic logic [15:0] prog_word(input int a);
        logic [2:0] d, s;
        d = 3'(a & 7);
        s = 3'((a >> 3) & 7);
        if ((a & 3) == 3) return {4'b0000, d, s, 6'b0};
        return {4'b1001, d, s, 6'b111111};
    endfunction

    // Flags of a value, per R8.
    function automatic logic [2:0] flags_of(input logic [15:0] v);
        if (v[15])       return 3'b100;
        if (v == 16'h0)  return 3'b010;
        return 3'b001;
    endfunction

    // Model state.
    logic [15:0] m_pc, m_mar, m_mdr, m_ir;
    logic [15:0] m_reg [8];
    logic [2:0]  m_cc;
    int          m_ph;

    initial begin
        bit seen_n = 0, seen_z = 0, seen_p = 0;
        logic [15:0] e_bus;
        logic [3:0]  e_own;
        bit          e_we;
        m_pc = 0; m_mar = 0; m_mdr = 0; m_ir = 0; m_cc = 3'b010; m_ph = 0;
        for (int k = 0; k < 8; k++) m_reg[k] = 16'(k * 16'h2493);

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values.
        check(pc_q == 16'h0, "R1 pc", 32'(pc_q), 0);
        check(phase_q == 2'd0, "R1 phase", 32'(phase_q), 0);
        check(nzp_q == 3'b010, "R1 flags", 32'(nzp_q), 32'b010);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < N_INSTR * 4; cyc++) begin
            e_bus = 16'h0; e_own = 4'b0000; e_we = 1'b0;
            case (m_ph)
                0: begin e_bus = m_pc;  e_own = 4'b0001; end
                2: begin e_bus = m_mdr; e_own = 4'b0010; end
                3: if (m_ir[15:12] == 4'b1001) begin
                       e_bus = ~m_reg[m_ir[8:6]]; e_own = 4'b0100; e_we = 1'b1;
                   end
                default: ;
            endcase
            check(phase_q == 2'(m_ph), "R10 phase", 32'(phase_q), 32'(m_ph));
            check(bus_owner == e_own, "R2 owner", 32'(bus_owner), 32'(e_own));
            if (m_ph == 3)
                check(bus_val == e_bus, "R7 R9 execute bus", 32'(bus_val), 32'(e_bus));
            else if (m_ph == 0)
                check(bus_val == e_bus, "R3 fetch bus", 32'(bus_val), 32'(e_bus));
            else
                check(bus_val == e_bus, "R4 R5 fetch bus", 32'(bus_val), 32'(e_bus));
            check(rf_we == e_we, "R7 R9 write strobe", 32'(rf_we), 32'(e_we));
            if (e_we)
                check(rf_waddr == m_ir[11:9], "R7 dest", 32'(rf_waddr), 32'(m_ir[11:9]));
            check(pc_q == m_pc, "R3 pc", 32'(pc_q), 32'(m_pc));
            check(ir_q == m_ir, "R5 R6 ir", 32'(ir_q), 32'(m_ir));
            check(nzp_q == m_cc, "R8 R9 flags", 32'(nzp_q), 32'(m_cc));

            // Advance the model by one clock.
            case (m_ph)
                0: begin m_mar = m_pc; m_pc = m_pc + 16'd1; end
                1: m_mdr = prog_word(int'(m_mar[5:0]));
                2: m_ir = m_mdr;
                default: if (e_we) begin
                    m_reg[m_ir[11:9]] = e_bus;
                    m_cc = flags_of(e_bus);
                    if (m_cc == 3'b100) seen_n = 1;
                    if (m_cc == 3'b010) seen_z = 1;
                    if (m_cc == 3'b001) seen_p = 1;
                end
            endcase
            m_ph = (m_ph + 1) % 4;
            @(negedge clk);
        end
        // R8: the program drives all three flag outcomes.
        check(seen_n && seen_z && seen_p, "R8 flag coverage",
              32'({seen_n, seen_z, seen_p}), 32'b111);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule